// File: doc/BRIEF.md
# NAND Flash Access Cycle Engine

This block turns single host accesses into asynchronous bus cycles for an 8-bit or 16-bit NAND flash on one chip-select. The host side is a plain request port with valid, write, offset, write data, byte enables, a ready signal and read data. The two top bits of the host offset pick one of four windows. A write to the command window sends one byte or word with the command latch strobe high. A write to the address window sends one byte or word with the address latch strobe high. An access anywhere in the data window streams one word to or from the flash array. The host sends a multi-byte flash address as a series of address-window writes, and the engine puts no limit on how many.

Each device cycle is timed by a counter that starts at zero in the cycle's first clock. Runtime inputs place the chip-enable assertion, the write-strobe and read-strobe edges, the read capture point and the last count of the cycle. All strobes come straight from flops, so they cannot glitch. The engine drives no external address lines. A separate detector synchronises the ready/busy pin and sets a sticky flag when the flash goes from busy to ready. The host clears that flag by writing a one through the control window.

Top module: `nand_cycle_engine`

## Requirements
- R1: A host write with a non-zero byte enable to window 0 (offset bits [top:top-1] = 2'b00) runs one device cycle in which `nand_cle` is high for every count and `nand_ale` stays low.
- R2: A host write with a non-zero byte enable to window 1 (2'b01) runs one device cycle in which `nand_ale` is high for every count and `nand_cle` stays low.
- R3: A read or a write with a non-zero byte enable to window 2 (2'b10) runs one device cycle at any offset inside the window, with both `nand_cle` and `nand_ale` low.
- R4: At count k of a cycle, `nand_ce_n` is low when k >= `cfg_ce_on`. On writes, `nand_we_n` is low when `cfg_we_on` <= k < `cfg_we_off`. On reads, `nand_re_n` is low when `cfg_re_on` <= k < `cfg_re_off`. Outside these ranges each of these three strobes is high.
- R5: On a write cycle, `nand_dq_oe` is high from count `cfg_we_on` to the end of the cycle and `nand_dq_o` carries the write data. On a read cycle, `nand_dq_oe` stays low for the whole cycle.
- R6: With `cfg_wide` = 0, only bits [7:0] are used: bits [15:8] of `nand_dq_o` and of the captured read data are zero. With `cfg_wide` = 1, all 16 bits are used.
- R7: A read cycle samples `nand_dq_i` in the clock whose count equals `cfg_cap`, and the sampled value appears on `host_rdata` once the cycle ends.
- R8: A cycle lasts `cfg_end`+1 clocks. During it `host_ready` is low and no request is accepted. At the end every device pin returns to idle and `host_ready` goes high.
- R9: These accesses start no device cycle, leave `host_ready` high and leave `host_rdata` unchanged: a write with all byte enables zero, a read of window 0 or window 1, and any access to window 3.
- R10: A low-to-high transition on `nand_rb`, after synchronisation, sets `rb_rise_flag`. A write to window 3 with wdata bit 0 = 1 clears it. A write to window 3 with bit 0 = 0 leaves it set.
- R11: Out of reset every strobe is inactive (`nand_ce_n`, `nand_we_n`, `nand_re_n` high; `nand_cle`, `nand_ale`, `nand_dq_oe` low), `host_ready` is high and `rb_rise_flag` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_offset | input | OFF_W | Host offset; the top two bits select the window |
| host_wdata | input | DW | Write data |
| host_be | input | DW/8 | Byte enables |
| host_ready | output | 1 | High when a request can be accepted |
| host_rdata | output | DW | Last captured read data |
| cfg_wide | input | 1 | 1 = 16-bit device, 0 = 8-bit device |
| cfg_ce_on | input | TW | Chip-enable assertion count |
| cfg_we_on | input | TW | Write-strobe assertion count |
| cfg_we_off | input | TW | Write-strobe release count |
| cfg_re_on | input | TW | Read-strobe assertion count |
| cfg_re_off | input | TW | Read-strobe release count |
| cfg_cap | input | TW | Read capture count |
| cfg_end | input | TW | Last count of a cycle |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_cle | output | 1 | Command latch strobe |
| nand_ale | output | 1 | Address latch strobe |
| nand_dq_o | output | DW | Data bus drive value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | DW | Data bus input |
| nand_rb | input | 1 | Ready/busy pin, asynchronous |
| rb_rise_flag | output | 1 | Sticky busy-to-ready flag |

## Verification
The bench builds the block with its default parameters: a 16-bit bus, 4-bit timing fields, an 8-bit offset and a two-stage synchroniser. These defaults let one build cover both the 8-bit and the 16-bit lane rules, because `cfg_wide` is switched at runtime. The access table is run under two timing sets. One asserts chip enable at count zero and the other delays it. The bench checks every strobe at every count of each cycle against the windows it computes itself, and varies the capture point and the cycle end between the two sets.

// File: rtl/nand_eng_pkg.sv
package nand_eng_pkg;

  // host window selected by the two top offset bits
  typedef enum logic [1:0] {
    WIN_CMD = 2'b00,
    WIN_ADR = 2'b01,
    WIN_DAT = 2'b10,
    WIN_CTL = 2'b11
  } win_e;

endpackage

// File: rtl/nand_win_decode.sv
module nand_win_decode
  import nand_eng_pkg::*;
#(
  parameter int unsigned BE_W = 2
) (
  input  logic            valid,
  input  logic            write,
  input  logic [1:0]      win_sel,
  input  logic [BE_W-1:0] be,
  input  logic            wdata_b0,
  input  logic            ready,
  output logic            start,
  output logic            start_write,
  output win_e            start_win,
  output logic            flag_clr
);

  win_e win;
  logic take;

  always_comb begin
    win         = win_e'(win_sel);
    take        = valid && ready;
    start_write = write;
    start_win   = win;
    start       = 1'b0;
    flag_clr    = 1'b0;
    if (take) begin
      if (write) begin
        start    = (|be) && (win != WIN_CTL);
        flag_clr = (win == WIN_CTL) && wdata_b0;
      end else begin
        start    = (win == WIN_DAT);
      end
    end
  end

endmodule

// File: rtl/nand_cycle_timer.sv
module nand_cycle_timer
  import nand_eng_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_write,
  input  win_e          start_win,
  input  logic [DW-1:0] start_wdata,
  input  logic          wide,
  input  logic [TW-1:0] ce_on,
  input  logic [TW-1:0] we_on,
  input  logic [TW-1:0] we_off,
  input  logic [TW-1:0] re_on,
  input  logic [TW-1:0] re_off,
  input  logic [TW-1:0] cap,
  input  logic [TW-1:0] last,
  input  logic [DW-1:0] dq_i,
  output logic          busy,
  output logic          ce_n,
  output logic          we_n,
  output logic          re_n,
  output logic          cle,
  output logic          ale,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe,
  output logic [DW-1:0] rdata
);

  localparam int unsigned HW = DW / 2;

  logic          busy_q, busy_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic          wr_q, wr_d;
  win_e          win_q, win_d;
  logic [DW-1:0] wdat_q, wdat_d;
  logic          ce_n_q, ce_n_d, we_n_q, we_n_d, re_n_q, re_n_d;
  logic          cle_q, cle_d, ale_q, ale_d, oe_q, oe_d;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          cap_en;

  // next state
  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    wr_d   = wr_q;
    win_d  = win_q;
    wdat_d = wdat_q;
    if (busy_q) begin
      if (cnt_q == last) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d  = cnt_q + 1'b1;
      end
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      wr_d   = start_write;
      win_d  = start_win;
      wdat_d = wide ? start_wdata : {{HW{1'b0}}, start_wdata[HW-1:0]};
    end
  end

  // pin values for the next count, registered so they cannot glitch
  always_comb begin
    ce_n_d = !(busy_d && (cnt_d >= ce_on));
    we_n_d = !(busy_d && wr_d && (cnt_d >= we_on) && (cnt_d < we_off));
    re_n_d = !(busy_d && !wr_d && (cnt_d >= re_on) && (cnt_d < re_off));
    cle_d  = busy_d && (win_d == WIN_CMD);
    ale_d  = busy_d && (win_d == WIN_ADR);
    oe_d   = busy_d && wr_d && (cnt_d >= we_on);
  end

  // read capture
  always_comb begin
    cap_en  = busy_q && !wr_q && (cnt_q == cap);
    rdata_d = wide ? dq_i : {{HW{1'b0}}, dq_i[HW-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      wr_q   <= 1'b0;
      win_q  <= WIN_DAT;
      wdat_q <= '0;
      ce_n_q <= 1'b1;
      we_n_q <= 1'b1;
      re_n_q <= 1'b1;
      cle_q  <= 1'b0;
      ale_q  <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      wr_q   <= wr_d;
      win_q  <= win_d;
      wdat_q <= wdat_d;
      ce_n_q <= ce_n_d;
      we_n_q <= we_n_d;
      re_n_q <= re_n_d;
      cle_q  <= cle_d;
      ale_q  <= ale_d;
      oe_q   <= oe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (cap_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign busy  = busy_q;
  assign ce_n  = ce_n_q;
  assign we_n  = we_n_q;
  assign re_n  = re_n_q;
  assign cle   = cle_q;
  assign ale   = ale_q;
  assign dq_o  = wdat_q;
  assign dq_oe = oe_q;
  assign rdata = rdata_q;

endmodule

// File: rtl/nand_rb_flag.sv
module nand_rb_flag #(
  parameter int unsigned SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_async,
  input  logic clr,
  output logic flag
);

  logic [SYNC-1:0] sync_q, sync_d;
  logic            last_q;
  logic            flag_q, flag_d;
  logic            rise;

  generate
    if (SYNC == 1) begin : g_one
      assign sync_d = rb_async;
    end else begin : g_chain
      assign sync_d = {sync_q[SYNC-2:0], rb_async};
    end
  endgenerate

  always_comb begin
    rise   = sync_q[SYNC-1] && !last_q;
    flag_d = flag_q;
    if (clr)  flag_d = 1'b0;
    if (rise) flag_d = 1'b1;
  end

  // idle state is "ready", so no edge is seen at reset release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[SYNC-1];
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

endmodule

// File: rtl/nand_cycle_engine.sv
module nand_cycle_engine
  import nand_eng_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned TW    = 4,
  parameter int unsigned OFF_W = 8,
  parameter int unsigned SYNC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  input  logic              host_write,
  input  logic [OFF_W-1:0]  host_offset,
  input  logic [DW-1:0]     host_wdata,
  input  logic [DW/8-1:0]   host_be,
  output logic              host_ready,
  output logic [DW-1:0]     host_rdata,
  input  logic              cfg_wide,
  input  logic [TW-1:0]     cfg_ce_on,
  input  logic [TW-1:0]     cfg_we_on,
  input  logic [TW-1:0]     cfg_we_off,
  input  logic [TW-1:0]     cfg_re_on,
  input  logic [TW-1:0]     cfg_re_off,
  input  logic [TW-1:0]     cfg_cap,
  input  logic [TW-1:0]     cfg_end,
  output logic              nand_ce_n,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic [DW-1:0]     nand_dq_o,
  output logic              nand_dq_oe,
  input  logic [DW-1:0]     nand_dq_i,
  input  logic              nand_rb,
  output logic              rb_rise_flag
);

  localparam int unsigned BE_W = DW / 8;

  logic start, start_write, flag_clr, busy;
  win_e start_win;
  logic unused_off;

  assign unused_off = ^host_offset[OFF_W-3:0];
  assign host_ready = !busy;

  nand_win_decode #(.BE_W(BE_W)) i_dec (
    .valid       (host_valid),
    .write       (host_write),
    .win_sel     (host_offset[OFF_W-1 -: 2]),
    .be          (host_be),
    .wdata_b0    (host_wdata[0]),
    .ready       (host_ready),
    .start       (start),
    .start_write (start_write),
    .start_win   (start_win),
    .flag_clr    (flag_clr)
  );

  nand_cycle_timer #(.DW(DW), .TW(TW)) i_tmr (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_write (start_write),
    .start_win   (start_win),
    .start_wdata (host_wdata),
    .wide        (cfg_wide),
    .ce_on       (cfg_ce_on),
    .we_on       (cfg_we_on),
    .we_off      (cfg_we_off),
    .re_on       (cfg_re_on),
    .re_off      (cfg_re_off),
    .cap         (cfg_cap),
    .last        (cfg_end),
    .dq_i        (nand_dq_i),
    .busy        (busy),
    .ce_n        (nand_ce_n),
    .we_n        (nand_we_n),
    .re_n        (nand_re_n),
    .cle         (nand_cle),
    .ale         (nand_ale),
    .dq_o        (nand_dq_o),
    .dq_oe       (nand_dq_oe),
    .rdata       (host_rdata)
  );

  nand_rb_flag #(.SYNC(SYNC)) i_rb (
    .clk      (clk),
    .rst_n    (rst_n),
    .rb_async (nand_rb),
    .clr      (flag_clr),
    .flag     (rb_rise_flag)
  );

endmodule

// File: rtl/nand_cycle_engine_chk.sv
module nand_cycle_engine_chk #(
  parameter int unsigned OFF_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_valid,
  input logic             host_write,
  input logic [OFF_W-1:0] host_offset,
  input logic             host_wdata0,
  input logic             host_ready,
  input logic             nand_ce_n,
  input logic             nand_we_n,
  input logic             nand_re_n,
  input logic             nand_cle,
  input logic             nand_ale,
  input logic             nand_dq_oe,
  input logic             rb_rise_flag
);

  // R1
  cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  // R4
  we_re_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  // R4
  strobe_in_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

  // R5
  oe_off_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_dq_oe);

  // R5
  oe_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_dq_oe && !host_ready) |=> (nand_dq_oe || host_ready));

  // R8
  idle_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> (nand_ce_n && nand_we_n && nand_re_n &&
                    !nand_cle && !nand_ale && !nand_dq_oe));

  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rb_rise_flag) |-> $past(host_valid && host_ready && host_write &&
                                  (host_offset[OFF_W-1 -: 2] == 2'b11) && host_wdata0));

endmodule

bind nand_cycle_engine nand_cycle_engine_chk #(.OFF_W(OFF_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_valid   (host_valid),
  .host_write   (host_write),
  .host_offset  (host_offset),
  .host_wdata0  (host_wdata[0]),
  .host_ready   (host_ready),
  .nand_ce_n    (nand_ce_n),
  .nand_we_n    (nand_we_n),
  .nand_re_n    (nand_re_n),
  .nand_cle     (nand_cle),
  .nand_ale     (nand_ale),
  .nand_dq_oe   (nand_dq_oe),
  .rb_rise_flag (rb_rise_flag)
);

// File: tb/test_nand_cycle_engine.sv
`timescale 1ns/1ps
module test_nand_cycle_engine;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_valid, host_write;
  logic [7:0]  host_offset;
  logic [15:0] host_wdata;
  logic [1:0]  host_be;
  logic        host_ready;
  logic [15:0] host_rdata;
  logic        cfg_wide;
  logic [3:0]  cfg_ce_on, cfg_we_on, cfg_we_off, cfg_re_on, cfg_re_off, cfg_cap, cfg_end;
  logic        nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe;
  logic [15:0] nand_dq_o, nand_dq_i;
  logic        nand_rb, rb_rise_flag;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  nand_cycle_engine i_nand_cycle_engine (.*);

  typedef struct packed {
    logic        wr;
    logic [1:0]  win;
    logic [5:0]  lo;
    logic [15:0] wd;
    logic [1:0]  be;
    logic        wide;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 6'h00, 16'h5570, 2'b01, 1'b0},
    '{1'b1, 2'd1, 6'h05, 16'h0012, 2'b01, 1'b0},
    '{1'b1, 2'd2, 6'h3F, 16'hBEEF, 2'b11, 1'b1},
    '{1'b0, 2'd2, 6'h00, 16'h0000, 2'b11, 1'b1},
    '{1'b0, 2'd2, 6'h2A, 16'h0000, 2'b11, 1'b0},
    '{1'b1, 2'd2, 6'h11, 16'h1234, 2'b11, 1'b0},
    '{1'b1, 2'd0, 6'h01, 16'h00FF, 2'b00, 1'b1},
    '{1'b0, 2'd1, 6'h00, 16'h0000, 2'b11, 1'b1},
    '{1'b1, 2'd1, 6'h09, 16'hAB12, 2'b10, 1'b1},
    '{1'b0, 2'd0, 6'h07, 16'h0000, 2'b11, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int ce, input int wo, input int wf, input int ro,
                         input int rf, input int cp, input int en);
    cfg_ce_on  = 4'(ce);
    cfg_we_on  = 4'(wo);
    cfg_we_off = 4'(wf);
    cfg_re_on  = 4'(ro);
    cfg_re_off = 4'(rf);
    cfg_cap    = 4'(cp);
    cfg_end    = 4'(en);
  endtask

  task automatic check_idle(input string req);
    chk(host_ready && nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe,
        req, {26'd0, host_ready, nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale} , 32'h3C);
  endtask

  function automatic logic [15:0] dq_pat(input int k);
    return 16'hC35A ^ 16'(k * 16'h1111);
  endfunction

  task automatic run_vec(input vec_t v);
    logic        dev;
    logic [15:0] rd_before, exp_dq, exp_rd;
    logic        e_ce, e_we, e_re, e_oe;
    string       wtag;
    dev = (v.wr && (v.be != 2'b00) && (v.win != 2'd3)) || (!v.wr && (v.win == 2'd2));
    wtag = (v.win == 2'd0) ? "R1" : (v.win == 2'd1) ? "R2" : "R3";
    cfg_wide = v.wide;
    rd_before = host_rdata;
    host_valid  = 1'b1;
    host_write  = v.wr;
    host_offset = {v.win, v.lo};
    host_wdata  = v.wd;
    host_be     = v.be;
    @(posedge clk);
    @(negedge clk);
    host_valid = 1'b0;
    if (!dev) begin
      // R9: no device cycle, read data untouched
      check_idle("R9");
      chk(host_rdata == rd_before, "R9", {16'd0, host_rdata}, {16'd0, rd_before});
      return;
    end
    exp_dq = v.wide ? v.wd : {8'h00, v.wd[7:0]};
    for (int k = 0; k <= int'(cfg_end); k++) begin
      e_ce = !(k >= int'(cfg_ce_on));
      e_we = !(v.wr && k >= int'(cfg_we_on) && k < int'(cfg_we_off));
      e_re = !(!v.wr && k >= int'(cfg_re_on) && k < int'(cfg_re_off));
      e_oe = v.wr && k >= int'(cfg_we_on);
      chk({nand_ce_n, nand_we_n, nand_re_n} == {e_ce, e_we, e_re}, "R4",
          {29'd0, nand_ce_n, nand_we_n, nand_re_n}, {29'd0, e_ce, e_we, e_re});
      chk({nand_cle, nand_ale} == {v.win == 2'd0, v.win == 2'd1}, wtag,
          {30'd0, nand_cle, nand_ale}, {30'd0, v.win == 2'd0, v.win == 2'd1});
      chk(nand_dq_oe == e_oe, "R5", {31'd0, nand_dq_oe}, {31'd0, e_oe});
      if (e_oe)
        chk(nand_dq_o == exp_dq, v.wide ? "R5" : "R6", {16'd0, nand_dq_o}, {16'd0, exp_dq});
      // R8: busy for the whole cycle
      chk(!host_ready, "R8", {31'd0, host_ready}, 32'd0);
      nand_dq_i = dq_pat(k);
      @(negedge clk);
    end
    // R8: back to idle right after the last count
    check_idle("R8");
    if (!v.wr) begin
      exp_rd = dq_pat(int'(cfg_cap));
      if (!v.wide) exp_rd = {8'h00, exp_rd[7:0]};
      chk(host_rdata == exp_rd, v.wide ? "R7" : "R6", {16'd0, host_rdata}, {16'd0, exp_rd});
    end
  endtask

  task automatic ctl_write(input logic b0);
    host_valid  = 1'b1;
    host_write  = 1'b1;
    host_offset = 8'hC0;
    host_wdata  = {15'd0, b0};
    host_be     = 2'b01;
    @(posedge clk);
    @(negedge clk);
    host_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    host_valid = 1'b0; host_write = 1'b0; host_offset = '0; host_wdata = '0; host_be = '0;
    cfg_wide = 1'b0; nand_dq_i = '0; nand_rb = 1'b1;
    set_cfg(0, 1, 3, 1, 4, 3, 5);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset state
    check_idle("R11");
    chk(rb_rise_flag == 1'b0, "R11", {31'd0, rb_rise_flag}, 32'd0);

    // table walked with two timing sets
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);
    set_cfg(2, 3, 6, 2, 7, 6, 8);
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R3: two data-window offsets give the same read data
    nand_dq_i = 16'h7E81;
    set_cfg(0, 0, 1, 0, 2, 0, 2);
    run_vec('{1'b0, 2'd2, 6'h01, 16'h0, 2'b11, 1'b1});
    run_vec('{1'b0, 2'd2, 6'h3E, 16'h0, 2'b11, 1'b1});

    // R8: request held while busy is not taken until ready
    set_cfg(0, 1, 3, 1, 4, 3, 5);
    host_valid = 1'b1; host_write = 1'b1; host_offset = 8'h80; host_wdata = 16'h4242; host_be = 2'b11;
    @(posedge clk);
    @(negedge clk);
    host_offset = 8'h00;
    @(negedge clk);
    chk(!host_ready && !nand_cle, "R8", {30'd0, host_ready, nand_cle}, 32'd0);
    host_valid = 1'b0;
    repeat (8) @(negedge clk);
    check_idle("R8");

    // R10: busy-to-ready edge sets the flag; W1C
    nand_rb = 1'b0;
    repeat (6) @(negedge clk);
    chk(rb_rise_flag == 1'b0, "R10", {31'd0, rb_rise_flag}, 32'd0);
    nand_rb = 1'b1;
    repeat (6) @(negedge clk);
    chk(rb_rise_flag == 1'b1, "R10", {31'd0, rb_rise_flag}, 32'd1);
    ctl_write(1'b0);
    chk(rb_rise_flag == 1'b1, "R10", {31'd0, rb_rise_flag}, 32'd1);
    check_idle("R9");
    ctl_write(1'b1);
    chk(rb_rise_flag == 1'b0, "R10", {31'd0, rb_rise_flag}, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule